// File: doc/BRIEF.md
# Four-Channel DMA Register Front End

This block is the byte-wide register interface of a four-channel DMA controller, seen from a host I/O bus. Each channel holds a sixteen-bit base address and a sixteen-bit base count. Both are reached eight bits at a time through one byte pointer that all channels share. A group of control ports sets the command, software requests, masks and channel modes. Reads return the status byte, the mask byte, and the live address or remaining count of any channel.

A small transfer engine sits behind the registers. In every clock cycle it picks the lowest-numbered channel that is unmasked and requesting, and moves that channel by one unit. The move advances the current address up or down and uses up one count. When the last unit is reached, the engine raises terminal count. The channel then either reloads from its base registers or masks itself.

The bus address is shifted right by a parameter (0 or 1) before decoding. This lets the block sit on either a byte-spaced or a word-spaced port range.

Top module: `dma4_regfront`

## Requirements
- R1: The port number is `bus_addr >> SHIFT` (4 bits). Port bit 3 = 0 selects a channel port: bit 0 picks address (0) or count (1), and bits 2:1 pick the channel. Port bit 3 = 1 selects a control port, with bits 2:0 as the control offset.
- R2: Every channel-port read or write toggles one shared byte pointer (reset 0). With the pointer at 0 the low byte is accessed, with it at 1 the high byte. Writing the high byte copies both base address and base count of that channel into its current address and remaining count.
- R3: Control offset 4 clears the byte pointer. Control offset 5 clears the pointer, the command and the status, and sets all four mask bits. The state after reset is the same.
- R4: Masks: offset 2 uses data bits 1:0 as the channel and sets its mask when bit 2 = 1, or clears it when bit 2 = 0. Offset 6 clears all masks. Offset 7 loads the masks from data bits 3:0. Reading offset 1 returns {4'b1111, mask[3:0]}.
- R5: A write to offset 1 uses data bits 1:0 as the channel. Bit 2 = 1 sets status bit (channel+4), the request. Bit 2 = 0 clears both the request and status bit (channel), the terminal-count flag.
- R6: Reading offset 0 returns the status byte, with requests in bits 7:4 and terminal-count flags in bits 3:0. That read then clears bits 3:0.
- R7: A write to offset 3 uses data bits 1:0 as the channel. It stores bit 4 (auto-reload) and bit 5 (address moves down) for that channel.
- R8: A channel is eligible when its mask bit is 0, its request bit is 1, and command bit 2 is 0. In each cycle the lowest-numbered eligible channel is serviced. The one-hot `grant` shows it in the following cycle.
- R9: A service puts the channel's current address on `xfer_addr`. The address then moves by +1 (or by −1 when the down bit is set), and the remaining count drops by 1. Reading a channel's address port returns its current address. Reading its count port returns the remaining count.
- R10: The service made while the remaining count is 0 (the base-count-plus-one-th unit) is terminal count. It pulses the channel's `tc_pulse` bit alongside `grant` and sets status bit (channel).
- R11: At terminal count, with auto-reload set the current address and remaining count reload from the base registers. Without auto-reload, the address and count keep moving and the channel's mask bit is set.
- R12: A command write (offset 0) keeps only bit 2 (service disable). Any other bit set pulses `cmd_reject` for one cycle, and that bit has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4+SHIFT | Host port address |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | One-cycle read strobe; read side effects take place at the edge that ends it |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid while rd_en is high |
| grant | output | 4 | One-hot channel serviced in the previous cycle |
| xfer_addr | output | 16 | Address used by that service |
| tc_pulse | output | 4 | Terminal-count pulse per channel |
| cmd_reject | output | 1 | Pulse after a command write with unsupported bits |

## Verification
The assertions take for granted that `wr_en` and `rd_en` are never high in the same cycle, and that address and data stay known while a strobe is high. The checks on grant eligibility and on command disable also assume that the bus never drives unknown values into mask or request state. The bench issues exactly one strobe per access, framed between falling edges, and holds every input at a defined value between accesses.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
    localparam int NCH  = 4;
    localparam int CH_W = $clog2(NCH);
    localparam int CW   = 16;

    typedef logic [CW-1:0] word_t;

    typedef enum logic [2:0] {
        CTL_STATUS = 3'd0,
        CTL_REQ    = 3'd1,
        CTL_MASK1  = 3'd2,
        CTL_MODE   = 3'd3,
        CTL_PTRCLR = 3'd4,
        CTL_MRESET = 3'd5,
        CTL_MCLR   = 3'd6,
        CTL_MALL   = 3'd7
    } ctl_off_e;

    localparam logic [7:0] CMD_HOLD  = 8'h04;
    localparam logic [7:0] CMD_UNSUP = 8'hFB;
    localparam int MODE_AUTO_BIT = 4;
    localparam int MODE_DOWN_BIT = 5;
    localparam int REQ_SEL_BIT   = 2;

    typedef struct packed {
        logic [7:0]              cmd;
        logic [2*NCH-1:0]        status;
        logic [NCH-1:0]          mask;
        logic                    ptr;
        word_t [NCH-1:0]         base_addr;
        word_t [NCH-1:0]         base_cnt;
        word_t [NCH-1:0]         cur_addr;
        word_t [NCH-1:0]         rem;
        logic [NCH-1:0]          m_auto;
        logic [NCH-1:0]          m_down;
        logic [NCH-1:0]          grant;
        word_t                   xaddr;
        logic [NCH-1:0]          tc;
        logic                    reject;
    } regs_t;
endpackage

// File: rtl/dma4_port_decode.sv
module dma4_port_decode
    import dma4_pkg::*;
#(
    parameter  int SHIFT  = 0,
    localparam int ADDR_W = 4 + SHIFT
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic              chan_wr,
    output logic              chan_rd,
    output logic              ctl_wr,
    output logic              ctl_rd,
    output logic [CH_W-1:0]   ch_sel,
    output logic              cnt_sel,
    output ctl_off_e          ctl_off
);
    logic [3:0] port;

    always_comb begin
        port    = bus_addr[ADDR_W-1:SHIFT];
        chan_wr = wr_en && !port[3];
        chan_rd = rd_en && !port[3];
        ctl_wr  = wr_en &&  port[3];
        ctl_rd  = rd_en &&  port[3];
        ch_sel  = port[2:1];
        cnt_sel = port[0];
        ctl_off = ctl_off_e'(port[2:0]);
    end
endmodule

// File: rtl/dma4_scan.sv
module dma4_scan
    import dma4_pkg::*;
(
    input  logic [NCH-1:0]  elig,
    output logic            found,
    output logic [CH_W-1:0] pick
);
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (elig[i]) begin
                found = 1'b1;
                pick  = CH_W'(i);
            end
        end
    end
endmodule

// File: rtl/dma4_chan_step.sv
module dma4_chan_step
    import dma4_pkg::*;
(
    input  word_t cur_addr,
    input  word_t rem,
    input  word_t base_addr,
    input  word_t base_cnt,
    input  logic  down,
    input  logic  auto_rl,
    output word_t nxt_addr,
    output word_t nxt_rem,
    output logic  at_tc
);
    word_t moved;

    always_comb begin
        at_tc = (rem == '0);
        moved = down ? cur_addr - word_t'(1) : cur_addr + word_t'(1);
        if (at_tc && auto_rl) begin
            nxt_addr = base_addr;
            nxt_rem  = base_cnt;
        end else begin
            nxt_addr = moved;
            nxt_rem  = rem - word_t'(1);
        end
    end
endmodule

// File: rtl/dma4_regfront.sv
module dma4_regfront
    import dma4_pkg::*;
#(
    parameter  int SHIFT  = 0,
    localparam int ADDR_W = 4 + SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    output logic [NCH-1:0]    grant,
    output logic [CW-1:0]     xfer_addr,
    output logic [NCH-1:0]    tc_pulse,
    output logic              cmd_reject
);
    regs_t r_q, r_d;

    logic            chan_wr, chan_rd, ctl_wr, ctl_rd, cnt_sel;
    logic [CH_W-1:0] ch_sel;
    ctl_off_e        ctl_off;
    logic [CH_W-1:0] wsel;
    logic [NCH-1:0]  elig;
    logic            found;
    logic [CH_W-1:0] pick;
    word_t [NCH-1:0] nxt_addr, nxt_rem;
    logic [NCH-1:0]  at_tc;
    word_t           rd_word;

    dma4_port_decode #(.SHIFT(SHIFT)) u_dec (
        .bus_addr (bus_addr),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .chan_wr  (chan_wr),
        .chan_rd  (chan_rd),
        .ctl_wr   (ctl_wr),
        .ctl_rd   (ctl_rd),
        .ch_sel   (ch_sel),
        .cnt_sel  (cnt_sel),
        .ctl_off  (ctl_off)
    );

    assign elig = ~r_q.mask & r_q.status[2*NCH-1:NCH] & {NCH{~r_q.cmd[2]}};

    dma4_scan u_scan (
        .elig  (elig),
        .found (found),
        .pick  (pick)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_step
        dma4_chan_step u_step (
            .cur_addr  (r_q.cur_addr[g]),
            .rem       (r_q.rem[g]),
            .base_addr (r_q.base_addr[g]),
            .base_cnt  (r_q.base_cnt[g]),
            .down      (r_q.m_down[g]),
            .auto_rl   (r_q.m_auto[g]),
            .nxt_addr  (nxt_addr[g]),
            .nxt_rem   (nxt_rem[g]),
            .at_tc     (at_tc[g])
        );
    end

    assign wsel = wr_data[CH_W-1:0];

    always_comb begin
        r_d        = r_q;
        r_d.grant  = '0;
        r_d.tc     = '0;
        r_d.reject = 1'b0;

        // host side: byte writes into base registers
        if (chan_wr) begin
            r_d.ptr = ~r_q.ptr;
            if (cnt_sel) begin
                if (r_q.ptr) r_d.base_cnt[ch_sel] = {wr_data, r_q.base_cnt[ch_sel][7:0]};
                else         r_d.base_cnt[ch_sel] = {r_q.base_cnt[ch_sel][CW-1:8], wr_data};
            end else begin
                if (r_q.ptr) r_d.base_addr[ch_sel] = {wr_data, r_q.base_addr[ch_sel][7:0]};
                else         r_d.base_addr[ch_sel] = {r_q.base_addr[ch_sel][CW-1:8], wr_data};
            end
        end
        if (chan_rd) r_d.ptr = ~r_q.ptr;
        if (ctl_rd && ctl_off == CTL_STATUS) r_d.status[NCH-1:0] = '0;

        // host side: control ports
        if (ctl_wr) begin
            unique case (ctl_off)
                CTL_STATUS: begin
                    r_d.cmd    = wr_data & ~CMD_UNSUP;
                    r_d.reject = |(wr_data & CMD_UNSUP);
                end
                CTL_REQ: begin
                    if (wr_data[REQ_SEL_BIT]) begin
                        r_d.status[NCH + int'(wsel)] = 1'b1;
                    end else begin
                        r_d.status[NCH + int'(wsel)] = 1'b0;
                        r_d.status[wsel]             = 1'b0;
                    end
                end
                CTL_MASK1: r_d.mask[wsel] = wr_data[REQ_SEL_BIT];
                CTL_MODE: begin
                    r_d.m_auto[wsel] = wr_data[MODE_AUTO_BIT];
                    r_d.m_down[wsel] = wr_data[MODE_DOWN_BIT];
                end
                CTL_PTRCLR: r_d.ptr = 1'b0;
                CTL_MRESET: begin
                    r_d.ptr    = 1'b0;
                    r_d.cmd    = '0;
                    r_d.status = '0;
                    r_d.mask   = '1;
                end
                CTL_MCLR: r_d.mask = '0;
                CTL_MALL: r_d.mask = wr_data[NCH-1:0];
            endcase
        end

        // transfer engine: one unit for the chosen channel
        if (found) begin
            r_d.grant[pick]    = 1'b1;
            r_d.xaddr          = r_q.cur_addr[pick];
            r_d.cur_addr[pick] = nxt_addr[pick];
            r_d.rem[pick]      = nxt_rem[pick];
            if (at_tc[pick]) begin
                r_d.tc[pick]     = 1'b1;
                r_d.status[pick] = 1'b1;
                if (!r_q.m_auto[pick]) r_d.mask[pick] = 1'b1;
            end
        end

        // high byte load restarts the channel, overriding the engine
        if (chan_wr && r_q.ptr) begin
            r_d.cur_addr[ch_sel] = r_d.base_addr[ch_sel];
            r_d.rem[ch_sel]      = r_d.base_cnt[ch_sel];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.mask <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rd_data = '0;
        rd_word = cnt_sel ? r_q.rem[ch_sel] : r_q.cur_addr[ch_sel];
        if (chan_rd) begin
            rd_data = r_q.ptr ? rd_word[CW-1:8] : rd_word[7:0];
        end else if (ctl_rd) begin
            if (ctl_off == CTL_STATUS)   rd_data = r_q.status;
            else if (ctl_off == CTL_REQ) rd_data = {4'hF, r_q.mask};
        end
    end

    assign grant      = r_q.grant;
    assign xfer_addr  = r_q.xaddr;
    assign tc_pulse   = r_q.tc;
    assign cmd_reject = r_q.reject;
endmodule

// File: rtl/dma4_regfront_chk.sv
module dma4_regfront_chk
    import dma4_pkg::*;
#(
    parameter  int SHIFT  = 0,
    localparam int ADDR_W = 4 + SHIFT
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              wr_en,
    input logic [NCH-1:0]    grant,
    input logic [NCH-1:0]    tc_pulse,
    input logic [NCH-1:0]    mask_q,
    input logic [2*NCH-1:0]  status_q,
    input logic [7:0]        cmd_q
);
    logic [3:0]     port;
    logic [NCH-1:0] elig_now;

    assign port     = bus_addr[ADDR_W-1:SHIFT];
    assign elig_now = ~mask_q & status_q[2*NCH-1:NCH] & {NCH{~cmd_q[2]}};

    a_r8_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    a_r8_grant_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |-> ((grant & ~$past(elig_now)) == '0));

    a_r10_tc_with_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_pulse & ~grant) == '0);

    a_r12_disable_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_q[2] |=> (grant == '0));

    a_r12_no_unsup_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q & CMD_UNSUP) == '0);

    a_r3_reset_masks: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && port == 4'hD) |=> (mask_q == '1 && cmd_q == '0));
endmodule

bind dma4_regfront dma4_regfront_chk #(.SHIFT(SHIFT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .wr_en    (wr_en),
    .grant    (grant),
    .tc_pulse (tc_pulse),
    .mask_q   (r_q.mask),
    .status_q (r_q.status),
    .cmd_q    (r_q.cmd)
);

// File: tb/dma4_regfront_tb_top.sv
`timescale 1ns/1ps
module dma4_regfront_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic [3:0]  grant, tc_pulse;
    logic [15:0] xfer_addr;
    logic        cmd_reject;

    int n_tests = 0, n_fail = 0;
    logic [15:0] m_base_addr [4];
    logic [15:0] m_base_cnt  [4];

    always #2.5 clk = ~clk;

    dma4_regfront dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rd_data(rd_data), .grant(grant), .xfer_addr(xfer_addr),
        .tc_pulse(tc_pulse), .cmd_reject(cmd_reject)
    );

    function automatic logic [3:0] cport(input int ch, input bit cnt);
        return {1'b0, 2'(ch), cnt};
    endfunction
    function automatic logic [3:0] kport(input int off);
        return {1'b1, 3'(off)};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic bwr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic brd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; rd_en = 1'b1;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic load_chan(input int ch, input logic [15:0] a, input logic [15:0] c);
        bwr(kport(4), 8'h00);
        bwr(cport(ch, 0), a[7:0]);
        bwr(cport(ch, 0), a[15:8]);
        bwr(cport(ch, 1), c[7:0]);
        bwr(cport(ch, 1), c[15:8]);
        m_base_addr[ch] = a;
        m_base_cnt[ch]  = c;
    endtask

    task automatic read_chan(input int ch, input bit cnt, output logic [15:0] v);
        logic [7:0] lo, hi;
        bwr(kport(4), 8'h00);
        brd(cport(ch, cnt), lo);
        brd(cport(ch, cnt), hi);
        v = {hi, lo};
    endtask

    function automatic logic [15:0] step_addr(input logic [15:0] a, input bit down);
        return down ? a - 16'd1 : a + 16'd1;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] v, ea;
        int          seed;
        seed = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state (R3)
        brd(kport(1), b); check("R3 mask after reset", b, 8'hFF);
        brd(kport(0), b); check("R3 status after reset", b, 8'h00);
        check("R8 grant after reset", grant, 4'h0);

        // random base loads and read-back, all channels masked (R1 R2)
        for (int i = 0; i < 4; i++) load_chan(i, 16'h0, 16'h0);
        for (int i = 0; i < 24; i++) begin
            int ch, rc;
            ch = int'($urandom_range(0, 3));
            load_chan(ch, 16'($urandom), 16'($urandom));
            rc = int'($urandom_range(0, 3));
            read_chan(rc, 0, v); check("R2 address readback", v, m_base_addr[rc]);
            read_chan(rc, 1, v); check("R1 count readback", v, m_base_cnt[rc]);
        end

        // pointer clear (R3)
        bwr(kport(4), 8'h00);
        bwr(cport(0, 0), 8'hAA);
        bwr(kport(4), 8'h00);
        bwr(cport(0, 0), 8'h34);
        bwr(cport(0, 0), 8'h12);
        read_chan(0, 0, v); check("R3 pointer clear", v, 16'h1234);

        // master reset clears pointer (R3)
        bwr(cport(0, 0), 8'h55);
        bwr(kport(5), 8'h00);
        bwr(cport(0, 0), 8'h78);
        bwr(cport(0, 0), 8'h56);
        read_chan(0, 0, v); check("R3 master reset pointer", v, 16'h5678);
        brd(kport(1), b); check("R3 master reset mask", b, 8'hFF);

        // mask ports (R4)
        bwr(kport(7), 8'h05); brd(kport(1), b); check("R4 write all masks", b, 8'hF5);
        bwr(kport(6), 8'h00); brd(kport(1), b); check("R4 clear all masks", b, 8'hF0);
        bwr(kport(2), 8'h06); brd(kport(1), b); check("R4 single mask set", b, 8'hF4);
        bwr(kport(2), 8'h02); brd(kport(1), b); check("R4 single mask clear", b, 8'hF0);
        bwr(kport(7), 8'h0F);

        // ch1: increment, no reload, count 3 (R7 R9 R10 R11)
        bwr(kport(3), 8'h01);
        load_chan(1, 16'h1230, 16'h0003);
        bwr(kport(1), 8'h05);
        bwr(kport(2), 8'h01);
        ea = 16'h1230;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R8 grant ch1", grant, 4'b0010);
            check("R9 xfer_addr up", xfer_addr, ea);
            check("R10 tc pulse ch1", tc_pulse, (k == 3) ? 4'b0010 : 4'b0000);
            ea = step_addr(ea, 1'b0);
        end
        @(negedge clk); check("R11 stop after tc", grant, 4'h0);
        brd(kport(1), b); check("R11 mask set at tc", b, 8'hFF);
        brd(kport(0), b); check("R10 status tc and req", b, 8'h22);
        brd(kport(0), b); check("R6 status tc cleared by read", b, 8'h20);
        read_chan(1, 1, v); check("R9 remaining count", v, 16'hFFFF);
        read_chan(1, 0, v); check("R9 current address", v, 16'h1234);
        bwr(kport(1), 8'h01);
        brd(kport(0), b); check("R5 request clear", b, 8'h00);

        // ch2: decrement with reload, count 1 (R7 R11)
        bwr(kport(3), 8'h32);
        load_chan(2, 16'h0100, 16'h0001);
        bwr(kport(1), 8'h06);
        bwr(kport(2), 8'h02);
        ea = 16'h0100;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R8 grant ch2", grant, 4'b0100);
            check("R11 reload address", xfer_addr, ea);
            check("R10 tc pulse ch2", tc_pulse, (k % 2 == 1) ? 4'b0100 : 4'b0000);
            ea = (k % 2 == 1) ? 16'h0100 : step_addr(ea, 1'b1);
        end

        // command handling (R12)
        bwr(kport(0), 8'h04);
        check("R12 no reject for bit 2", cmd_reject, 1'b0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); check("R12 service disabled", grant, 4'h0);
        end
        bwr(kport(0), 8'h00);
        @(negedge clk); check("R12 service resumes", grant, 4'b0100);
        bwr(kport(0), 8'h01);
        check("R12 reject unsupported", cmd_reject, 1'b1);
        @(negedge clk); check("R12 unsupported bit ignored", grant, 4'b0100);
        check("R12 reject is one pulse", cmd_reject, 1'b0);
        bwr(kport(2), 8'h06);
        bwr(kport(1), 8'h02);
        @(negedge clk); check("R4 masked channel idle", grant, 4'h0);
        brd(kport(0), b);

        // fixed priority ch0 before ch3 (R8)
        bwr(kport(3), 8'h00);
        bwr(kport(3), 8'h03);
        load_chan(0, 16'h0010, 16'h0001);
        load_chan(3, 16'h0300, 16'h0000);
        bwr(kport(1), 8'h04);
        bwr(kport(1), 8'h07);
        bwr(kport(7), 8'h06);
        @(negedge clk); check("R8 priority first ch0", {grant, xfer_addr}, {4'b0001, 16'h0010});
        @(negedge clk); check("R8 priority ch0 tc", {tc_pulse, xfer_addr}, {4'b0001, 16'h0011});
        @(negedge clk); check("R8 then ch3", {grant, tc_pulse, xfer_addr}, {4'b1000, 4'b1000, 16'h0300});
        @(negedge clk); check("R11 all done", grant, 4'h0);
        bwr(kport(1), 8'h00);
        brd(kport(0), b); check("R5 clear req clears tc", b, 8'h88);
        brd(kport(0), b); check("R6 read clears tc nibble", b, 8'h80);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule